// File: doc/BRIEF.md
# Sixteen-Bit Timer, Event Counter and Pulse-Width Meter

This block is a 16-bit up-counter for a small microcontroller. Software reaches it through a byte-wide register port. A control register picks what the counter counts. In timer mode it counts a divided system clock. In event mode it counts edges on an external input pin. In pulse mode it times one level held on that pin and then disarms itself.

When the counter passes the all-ones value it reloads from a preload register. It then raises a sticky interrupt flag and gives a one-cycle wake request to the power-control logic. The preload and the counter are both written as one 16-bit word. The low byte is first staged in a buffer, and the whole value is committed when the high byte is written.

Top module: `evt_pulse_timer`

## Requirements
- R1: After reset the control register, low buffer, preload and counter are zero, so every register address reads 0x00, and `irq` and `wake` are low.
- R2: A write to address 0 changes only the low buffer. Reading address 0 returns that buffer. The live counter (address 3 low byte, address 1 high byte) and the preload stay as they were.
- R3: A write to address 1 loads both the counter and the preload with {written byte, low buffer} at the same clock edge.
- R4: In timer mode (control bits 7:6 = 2'b10) with the run bit (control bit 4) set, the counter advances by one every 4 system clocks. The first step lands on the 4th rising edge after the control write.
- R5: In event mode (control bits 7:6 = 2'b01) with run set, the counter advances once per edge on `tmr_pin`. Control bit 3 = 1 selects rising edges and 0 selects falling edges. The pin passes through a two-flop synchroniser, so a change counts on the 3rd rising edge after it.
- R6: An increment from 0xFFFF loads the preload value instead, sets the flag (control bit 0) and pulses `wake` high for one cycle, whatever the state of `irq_en`.
- R7: In timer and event modes the run bit stays set through overflows. Only a control write clears it.
- R8: In pulse mode (control bits 7:6 = 2'b11) with run set, the counter stays idle until the active edge chosen by bit 3. It then advances once per 4 clocks while the pin holds that level. When the pin returns, it stops and clears the run bit. A level lasting H clocks adds floor(H/4).
- R9: After a measurement, later pin activity leaves the counter unchanged until software sets run again.
- R10: The flag stays set until a control write with bit 0 = 0. A write with bit 0 = 1 leaves it set. `irq` equals the flag ANDed with `irq_en`.
- R11: With mode 2'b00, or with run clear in any mode, the counter does not change whatever the pin does.
- R12: Address 2 reads the control register as {mode[1:0], 0, run, edge, 0, 0, flag}. Address 1 reads the counter high byte and address 3 reads the counter low byte. `rdata` is 0x00 while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address: 0 low buffer, 1 high byte, 2 control, 3 live low byte |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data (combinational) |
| tmr_pin | input | 1 | External event / pulse input, asynchronous |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request: flag AND enable |
| wake | output | 1 | One-cycle wake request on every overflow |

## Verification
Register writes take effect at the edge that samples the strobe. A timer step is due on the 4th edge after the enabling write. A pin change is counted on the 3rd edge after it. An overflow shows its reload, flag and `wake` together after the edge that wraps, and `wake` is gone one edge later. Each scenario counts rising edges from the point where it drives a stimulus and reads results only at falling edges. It checks both the cycle before a step is due and the cycle it lands: two edges after a pin change the counter must still be unchanged, and after the third it must have moved.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

   typedef enum logic [1:0] {
      MODE_OFF   = 2'b00,
      MODE_EVENT = 2'b01,
      MODE_TIMER = 2'b10,
      MODE_PULSE = 2'b11
   } ptmr_mode_e;

   localparam logic [1:0] ADR_LOW  = 2'd0;
   localparam logic [1:0] ADR_HIGH = 2'd1;
   localparam logic [1:0] ADR_CTRL = 2'd2;
   localparam logic [1:0] ADR_LIVE = 2'd3;

   localparam int CTL_MODE_LSB = 6;
   localparam int CTL_RUN      = 4;
   localparam int CTL_EDGE     = 3;
   localparam int CTL_FLAG     = 0;

endpackage

// File: rtl/ptmr_sync_edge.sv
module ptmr_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise,
   output logic fall
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ptmr_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              prev;
   logic              level;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         prev  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], pin};
         prev  <= chain[STAGES-1];
      end
   end

   assign level = chain[STAGES-1];
   assign rise  = level & ~prev;
   assign fall  = ~level & prev;

   // a detected edge lasts exactly one cycle
   assert_rise_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
   assert_fall_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall);

endmodule

// File: rtl/ptmr_prescale.sv
module ptmr_prescale #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);

   if (DIV < 2) begin : g_bad_div
      $error("ptmr_prescale: DIV must be at least 2");
   end

   localparam int  PW   = (DIV > 1) ? $clog2(DIV) : 1;
   localparam bit  POW2 = ((DIV & (DIV - 1)) == 0);

   logic [PW-1:0] phase;

   if (POW2) begin : g_pow2
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   phase <= '0;
         else if (!en) phase <= '0;
         else          phase <= phase + 1'b1;
      end
      assign tick = en & (&phase);
   end else begin : g_cmp
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     phase <= '0;
         else if (!en || phase == LAST)  phase <= '0;
         else                            phase <= phase + 1'b1;
      end
      assign tick = en & (phase == LAST);
   end

   // ticks are never back to back
   assert_tick_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/ptmr_regs.sv
module ptmr_regs
   import ptmr_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic                  rd_en,
   input  logic [1:0]            addr,
   input  logic [DATA_W-1:0]     wdata,
   input  logic [2*DATA_W-1:0]   cnt,
   input  logic                  hw_run_clr,
   input  logic                  ovf,
   input  logic                  irq_en,
   output logic [DATA_W-1:0]     rdata,
   output logic [DATA_W-1:0]     lowbuf,
   output logic                  hi_load,
   output logic                  ctrl_wr,
   output ptmr_mode_e            mode,
   output logic                  run,
   output logic                  edge_hi,
   output logic                  irq
);

   if (DATA_W < 8) begin : g_bad_width
      $error("ptmr_regs: DATA_W must be at least 8");
   end

   logic flag;
   logic [7:0] ctrl_view;

   assign hi_load = wr_en && (addr == ADR_HIGH);
   assign ctrl_wr = wr_en && (addr == ADR_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lowbuf  <= '0;
         mode    <= MODE_OFF;
         run     <= 1'b0;
         edge_hi <= 1'b0;
         flag    <= 1'b0;
      end else begin
         if (wr_en && addr == ADR_LOW) lowbuf <= wdata;
         if (ctrl_wr) begin
            mode    <= ptmr_mode_e'(wdata[CTL_MODE_LSB +: 2]);
            run     <= wdata[CTL_RUN];
            edge_hi <= wdata[CTL_EDGE];
         end else if (hw_run_clr) begin
            run <= 1'b0;
         end
         if (ovf)                               flag <= 1'b1;
         else if (ctrl_wr && !wdata[CTL_FLAG])  flag <= 1'b0;
      end
   end

   assign ctrl_view = {mode, 1'b0, run, edge_hi, 2'b00, flag};
   assign irq       = flag & irq_en;

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         unique case (addr)
            ADR_LOW:  rdata = lowbuf;
            ADR_HIGH: rdata = cnt[2*DATA_W-1:DATA_W];
            ADR_CTRL: rdata = DATA_W'(ctrl_view);
            ADR_LIVE: rdata = cnt[DATA_W-1:0];
            default:  rdata = '0;
         endcase
      end
   end

   assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !(ctrl_wr && !wdata[CTL_FLAG])) |=> flag);
   assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq);
   assert_run_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !ctrl_wr && !hw_run_clr) |=> run);

endmodule

// File: rtl/ptmr_count.sv
module ptmr_count
   import ptmr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ptmr_mode_e       mode,
   input  logic             run,
   input  logic             edge_hi,
   input  logic             ctrl_wr,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             rise,
   input  logic             fall,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt,
   output logic             ovf,
   output logic             run_clr,
   output logic             presc_en,
   output logic             wake
);

   logic [CNT_W-1:0] preload;
   logic             meas;
   logic             act_edge, end_edge, armed, inc, at_top;

   assign act_edge = edge_hi ? rise : fall;
   assign end_edge = edge_hi ? fall : rise;
   assign armed    = run && (mode == MODE_PULSE);

   // one-shot measurement window
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         meas <= 1'b0;
      else if (ctrl_wr)                   meas <= 1'b0;
      else if (meas && end_edge)          meas <= 1'b0;
      else if (armed && !meas && act_edge) meas <= 1'b1;
   end

   assign run_clr  = meas && end_edge;
   assign presc_en = (run && mode == MODE_TIMER) || meas;
   assign inc      = tick || (run && mode == MODE_EVENT && act_edge);
   assign at_top   = &cnt;
   assign ovf      = inc && at_top && !load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         preload <= '0;
         wake    <= 1'b0;
      end else begin
         wake <= ovf;
         if (load) begin
            cnt     <= load_val;
            preload <= load_val;
         end else if (inc) begin
            cnt <= at_top ? preload : cnt + 1'b1;
         end
      end
   end

   assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt == $past(load_val)) && (preload == $past(load_val)));
   assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> (cnt == $past(preload)) && wake);
   assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !load && !at_top) |=> cnt == $past(cnt) + 1'b1);
   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !load) |=> $stable(cnt));
   assert_oneshot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(meas) && !$past(ctrl_wr)) |-> !run);

endmodule

// File: rtl/evt_pulse_timer.sv
module evt_pulse_timer
   import ptmr_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int PRESCALE    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              tmr_pin,
   input  logic              irq_en,
   output logic              irq,
   output logic              wake
);

   localparam int CNT_W = 2 * DATA_W;

   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] lowbuf;
   logic              hi_load, ctrl_wr, run, edge_hi;
   logic              rise, fall, tick, presc_en, ovf, run_clr;
   ptmr_mode_e        mode;

   ptmr_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .pin(tmr_pin), .rise(rise), .fall(fall));

   ptmr_prescale #(.DIV(PRESCALE)) i_presc (
      .clk(clk), .rst_n(rst_n), .en(presc_en), .tick(tick));

   ptmr_regs #(.DATA_W(DATA_W)) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .cnt(cnt), .hw_run_clr(run_clr), .ovf(ovf),
      .irq_en(irq_en), .rdata(rdata), .lowbuf(lowbuf), .hi_load(hi_load),
      .ctrl_wr(ctrl_wr), .mode(mode), .run(run), .edge_hi(edge_hi), .irq(irq));

   ptmr_count #(.CNT_W(CNT_W)) i_count (
      .clk(clk), .rst_n(rst_n), .mode(mode), .run(run), .edge_hi(edge_hi),
      .ctrl_wr(ctrl_wr), .load(hi_load), .load_val({wdata, lowbuf}),
      .rise(rise), .fall(fall), .tick(tick), .cnt(cnt), .ovf(ovf),
      .run_clr(run_clr), .presc_en(presc_en), .wake(wake));

   assert_wake_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wake |=> !wake);

endmodule

// File: tb/test_evt_pulse_timer.sv
`timescale 1ns/1ps
module test_evt_pulse_timer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, rd_en = 1'b0, tmr_pin = 1'b0, irq_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       irq, wake;
   int         n_chk = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   evt_pulse_timer i_evt_pulse_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .tmr_pin(tmr_pin), .irq_en(irq_en),
      .irq(irq), .wake(wake));

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(posedge clk);
      #1 wr_en = 1'b0;
   endtask

   // call at a falling edge; consumes no clock edge
   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      addr = a; rd_en = 1'b1;
      #0.5 d = rdata;
      rd_en = 1'b0;
   endtask

   task automatic rd_cnt(output logic [15:0] c);
      logic [7:0] h, l;
      rd(2'd1, h); rd(2'd3, l);
      c = {h, l};
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset;
      logic [7:0] v;
      @(negedge clk);
      for (int a = 0; a < 4; a++) begin
         rd(a[1:0], v);
         chk("R1 reset register", {8'h0, v}, 16'h0000);
      end
      chk("R1 reset irq/wake", {14'h0, irq, wake}, 16'h0);
      addr = 2'd2;
      #0.2 chk("R12 rdata idle without rd_en", {8'h0, rdata}, 16'h0000);
   endtask

   task automatic t_bytes;
      logic [7:0] v; logic [15:0] c;
      wr(2'd0, 8'h77); wr(2'd1, 8'h44);      // counter 0x4477
      wr(2'd0, 8'h5A);
      @(negedge clk);
      rd_cnt(c); chk("R2 low write leaves counter", c, 16'h4477);
      rd(2'd0, v); chk("R2 low buffer readback", {8'h0, v}, 16'h005A);
      wr(2'd1, 8'h12);
      @(negedge clk);
      rd_cnt(c); chk("R3 high write commits word", c, 16'h125A);
      rd(2'd1, v); chk("R12 high address reads live high", {8'h0, v}, 16'h0012);
   endtask

   task automatic t_timer_ovf;
      logic [7:0] v; logic [15:0] c;
      irq_en = 1'b0;
      wr(2'd0, 8'hFE); wr(2'd1, 8'hFF);      // counter & preload 0xFFFE
      wr(2'd0, 8'h33);                      // buffer only
      wr(2'd2, 8'h90);                      // timer, run
      edges(3);
      rd_cnt(c); chk("R4 no step before 4th edge", c, 16'hFFFE);
      edges(1);
      rd_cnt(c); chk("R4 step on 4th edge", c, 16'hFFFF);
      chk("R6 no wake before wrap", {15'h0, wake}, 16'h0);
      edges(4);
      rd_cnt(c); chk("R6 reload from preload, R2 preload untouched", c, 16'hFFFE);
      chk("R6 wake pulse without irq_en", {15'h0, wake}, 16'h1);
      rd(2'd2, v); chk("R7 run kept, R6 flag set", {8'h0, v}, 16'h0091);
      chk("R10 irq masked", {15'h0, irq}, 16'h0);
      irq_en = 1'b1;
      #0.2 chk("R10 irq with enable", {15'h0, irq}, 16'h1);
      edges(1);
      chk("R6 wake one cycle", {15'h0, wake}, 16'h0);
      wr(2'd2, 8'h91);
      @(negedge clk);
      rd(2'd2, v); chk("R10 flag kept on bit0=1 write", {8'h0, v}, 16'h0091);
      wr(2'd2, 8'h00);
      @(negedge clk);
      rd(2'd2, v); chk("R10 flag cleared", {8'h0, v}, 16'h0000);
      chk("R10 irq dropped", {15'h0, irq}, 16'h0);
      irq_en = 1'b0;
   endtask

   task automatic t_event;
      logic [15:0] c;
      wr(2'd0, 8'h00); wr(2'd1, 8'h00);
      wr(2'd2, 8'h58);                      // event, run, rising
      @(negedge clk); tmr_pin = 1'b1;
      edges(2);
      rd_cnt(c); chk("R5 not counted after 2 edges", c, 16'h0000);
      edges(1);
      rd_cnt(c); chk("R5 rising counted on 3rd edge", c, 16'h0001);
      tmr_pin = 1'b0; edges(5);
      rd_cnt(c); chk("R5 falling ignored with edge=1", c, 16'h0001);
      for (int i = 0; i < 3; i++) begin
         tmr_pin = 1'b1; edges(3); tmr_pin = 1'b0; edges(3);
      end
      rd_cnt(c); chk("R5 several rising edges", c, 16'h0004);
      wr(2'd2, 8'h50);                      // falling edges
      @(negedge clk); tmr_pin = 1'b1; edges(5);
      rd_cnt(c); chk("R5 rising ignored with edge=0", c, 16'h0004);
      tmr_pin = 1'b0; edges(3);
      rd_cnt(c); chk("R5 falling counted", c, 16'h0005);
      wr(2'd2, 8'h00);
   endtask

   task automatic t_pulse;
      logic [7:0] v; logic [15:0] c;
      wr(2'd0, 8'h00); wr(2'd1, 8'h00);
      wr(2'd2, 8'hD8);                      // pulse, run, high level
      edges(6);
      rd_cnt(c); chk("R8 armed counter idle", c, 16'h0000);
      tmr_pin = 1'b1;
      repeat (40) @(posedge clk);
      @(negedge clk); tmr_pin = 1'b0;
      edges(6);
      rd_cnt(c); chk("R8 high level of 40 clocks", c, 16'h000A);
      rd(2'd2, v); chk("R8 run self-cleared", {8'h0, v}, 16'h00C8);
      tmr_pin = 1'b1; edges(20); tmr_pin = 1'b0; edges(6);
      rd_cnt(c); chk("R9 second pulse ignored", c, 16'h000A);
      wr(2'd0, 8'h00); wr(2'd1, 8'h00);
      @(negedge clk); tmr_pin = 1'b1; edges(5);
      wr(2'd2, 8'hD0);                      // pulse, run, low level
      edges(3); tmr_pin = 1'b0;
      repeat (17) @(posedge clk);
      @(negedge clk); tmr_pin = 1'b1;
      edges(6);
      rd_cnt(c); chk("R8 low level of 17 clocks", c, 16'h0004);
      rd(2'd2, v); chk("R8 run self-cleared low", {8'h0, v}, 16'h00C0);
      tmr_pin = 1'b0; edges(4);
   endtask

   task automatic t_idle;
      logic [15:0] c;
      wr(2'd0, 8'h21); wr(2'd1, 8'h43);
      wr(2'd2, 8'h10);                      // mode off, run set
      @(negedge clk);
      for (int i = 0; i < 2; i++) begin
         tmr_pin = 1'b1; edges(4); tmr_pin = 1'b0; edges(4);
      end
      rd_cnt(c); chk("R11 mode off holds", c, 16'h4321);
      wr(2'd2, 8'h80); edges(20);
      rd_cnt(c); chk("R11 timer without run holds", c, 16'h4321);
      wr(2'd2, 8'h48);
      @(negedge clk); tmr_pin = 1'b1; edges(4); tmr_pin = 1'b0; edges(4);
      rd_cnt(c); chk("R11 event without run holds", c, 16'h4321);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_bytes();
      t_timer_ovf();
      t_event();
      t_pulse();
      t_idle();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule